// File: doc/BRIEF.md
# Data Storage Access Exception Checker

This block sits beside the load/store pipeline and judges one memory-accessing instruction per valid strobe. It looks at the instruction's access class, the current privilege mode and the attributes of the page already found by translation: user and supervisor write enables, byte order, and which byte orders an attached coprocessor can handle. It also sees the two user cache-lock enables, the load-reserve reservation flag and a zero-length flag for string transfers. From these it decides whether a data storage exception is raised and with which cause.

It also settles the cases where a fault is found but no interrupt may be taken. A store-conditional that has lost its reservation completes and reports failure instead of trapping. A zero-length string transfer that faults becomes a no-op. Cache-lock faults are raised from the enable bits and the mode alone, so the state of the target line plays no part. All results are registered and appear exactly one clock after the valid strobe.

Access class codes on `accClass`: 0 no access, 1 integer load, 2 integer store, 3 store-conditional, 4 cache-block zero, 5 data cache-block invalidate, 6 instruction cache-block invalidate, 7 data cache-block flush, 8 coprocessor load, 9 coprocessor store, 10 string load, 11 string store, 12 data cache touch, 13 instruction cache touch. Codes 14 and 15 are treated as no access.

Top module: `dsx_checker`

## Requirements
- R1: In user mode (`userMode`=1), classes 2, 3, 4, 5, 9 and 11 on a page with `pageUserWr`=0 give cause 1 (write access) and `irqReq`=1.
- R2: In supervisor mode (`userMode`=0), the same write classes give cause 1 when `pageSupWr`=0, and the user write bit is then ignored.
- R3: In user mode with `icUserLock`=1, class 6 gives cause 3 (cache locking) with `irqReq`=1. In supervisor mode, or with the enable clear, it gives cause 0.
- R4: In user mode with `dcUserLock`=1, class 7 gives cause 3 with `irqReq`=1. In supervisor mode, or with the enable clear, it gives cause 0.
- R5: Classes 8 and 9 give cause 2 (byte ordering) when `copOrderOk[pageLittle]`=0. Bit 0 means big-endian support and bit 1 little-endian support. Integer classes 1 and 2 never give cause 2.
- R6: A store-conditional (class 3) that would give cause 1 while `resvHeld`=0 gives cause 0, `irqReq`=0 and `scFail`=1.
- R7: A store-conditional that passes the write check gives cause 0 and `irqReq`=0, with `scFail` equal to the inverse of `resvHeld`. If it fails the check while `resvHeld`=1, it gives cause 1 with `scFail`=0.
- R8: A string transfer (class 10 or 11) with `lenZero`=1 that would raise an exception gives `noOp`=1, cause 0 and `irqReq`=0. The same transfer with `lenZero`=0 raises normally. Touch classes 12 and 13 never set `irqReq`.
- R9: When several conditions hold together, the cause follows the priority write access, then byte ordering, then cache locking.
- R10: Outputs change only in the cycle after `inValid`=1, when `resValid`=1. After a cycle with `inValid`=0, `resValid`, `irqReq`, `noOp` and `scFail` are 0 and cause is 0.
- R11: A synchronous active-high `rst` clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Instruction present for checking this cycle |
| accClass | input | 4 | Access class code |
| userMode | input | 1 | 1 = user mode, 0 = supervisor mode |
| pageUserWr | input | 1 | Page writable in user mode |
| pageSupWr | input | 1 | Page writable in supervisor mode |
| pageLittle | input | 1 | Page byte order, 1 = little-endian |
| copOrderOk | input | 2 | Coprocessor support per byte order (bit 0 big, bit 1 little) |
| icUserLock | input | 1 | User instruction-cache lock fault enable |
| dcUserLock | input | 1 | User data-cache lock fault enable |
| resvHeld | input | 1 | Load-reserve reservation is held |
| lenZero | input | 1 | String transfer length is zero |
| resValid | output | 1 | Result valid, one cycle after inValid |
| cause | output | 3 | 0 none, 1 write access, 2 byte ordering, 3 cache locking |
| irqReq | output | 1 | Data storage interrupt request strobe |
| noOp | output | 1 | Instruction is turned into a no-op |
| scFail | output | 1 | Store-conditional failed |

## Verification
The hardest situations to reach are the suppression corners. Each needs a fault and a swallowing condition in the same cycle: a store-conditional with a denied write and no reservation, or a zero-length string store to a read-only page in the mode that matters. Directed stimulus builds each of these and its near miss, where only the reservation or the length flag changes, so the bench can see the interrupt appear and disappear. A long randomized stream with back-to-back valid cycles then mixes every class with every attribute combination, covering overlaps such as a coprocessor store that faults on both write permission and byte order. Every cycle of that stream is compared against a behavioural model.

// File: rtl/dsx_pkg.sv
package dsx_pkg;

  localparam int CLS_W   = 4;
  localparam int CAUSE_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_NONE   = 4'd0,
    CLS_LOAD   = 4'd1,
    CLS_STORE  = 4'd2,
    CLS_STCX   = 4'd3,
    CLS_DZERO  = 4'd4,
    CLS_DINVAL = 4'd5,
    CLS_IINVAL = 4'd6,
    CLS_DFLUSH = 4'd7,
    CLS_COPLD  = 4'd8,
    CLS_COPST  = 4'd9,
    CLS_STRLD  = 4'd10,
    CLS_STRST  = 4'd11,
    CLS_DTOUCH = 4'd12,
    CLS_ITOUCH = 4'd13
  } accClass_e;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE  = 3'd0,
    CAUSE_WRITE = 3'd1,
    CAUSE_ORDER = 3'd2,
    CAUSE_LOCK  = 3'd3
  } cause_e;

  // Strobes from the class decoder to the datapath
  typedef struct packed {
    logic doesWrite;
    logic coprocAcc;
    logic icInval;
    logic dcFlush;
    logic storeCond;
    logic strXfer;
    logic touch;
  } clsDecode_t;

endpackage

// File: rtl/dsx_ctrl.sv
module dsx_ctrl
  import dsx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [CLS_W-1:0] accClass,
  output clsDecode_t       dec
);

  always_comb begin
    dec = '0;
    unique case (accClass)
      CLS_STORE:  dec.doesWrite = 1'b1;
      CLS_STCX: begin
        dec.doesWrite = 1'b1;
        dec.storeCond = 1'b1;
      end
      CLS_DZERO:  dec.doesWrite = 1'b1;
      CLS_DINVAL: dec.doesWrite = 1'b1;
      CLS_IINVAL: dec.icInval   = 1'b1;
      CLS_DFLUSH: dec.dcFlush   = 1'b1;
      CLS_COPLD:  dec.coprocAcc = 1'b1;
      CLS_COPST: begin
        dec.coprocAcc = 1'b1;
        dec.doesWrite = 1'b1;
      end
      CLS_STRLD:  dec.strXfer   = 1'b1;
      CLS_STRST: begin
        dec.strXfer   = 1'b1;
        dec.doesWrite = 1'b1;
      end
      CLS_DTOUCH: dec.touch     = 1'b1;
      CLS_ITOUCH: dec.touch     = 1'b1;
      default:    dec = '0;
    endcase
  end

  // R9: lock families never combine with write or coprocessor families
  a_r9_lock_exclusive: assert property (@(posedge clk) disable iff (rst)
    (dec.icInval || dec.dcFlush) |-> !(dec.doesWrite || dec.coprocAcc));

  a_r8_touch_alone: assert property (@(posedge clk) disable iff (rst)
    dec.touch |-> $countones(dec) == 1);

endmodule

// File: rtl/dsx_datapath.sv
module dsx_datapath
  import dsx_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  clsDecode_t         dec,
  input  logic               userMode,
  input  logic               pageUserWr,
  input  logic               pageSupWr,
  input  logic               pageLittle,
  input  logic [1:0]         copOrderOk,
  input  logic               icUserLock,
  input  logic               dcUserLock,
  input  logic               resvHeld,
  input  logic               lenZero,
  output logic               resValid,
  output logic [CAUSE_W-1:0] cause,
  output logic               irqReq,
  output logic               noOp,
  output logic               scFail
);

  logic   wrPerm, wrFault, ordFault, lockFault;
  logic   scLost, swallow, suppress;
  cause_e rawCause, finalCause;

  always_comb begin
    wrPerm    = userMode ? pageUserWr : pageSupWr;
    wrFault   = dec.doesWrite && !wrPerm;
    ordFault  = dec.coprocAcc && !copOrderOk[pageLittle];
    lockFault = userMode && ((dec.icInval && icUserLock) ||
                             (dec.dcFlush && dcUserLock));
    if (wrFault)        rawCause = CAUSE_WRITE;
    else if (ordFault)  rawCause = CAUSE_ORDER;
    else if (lockFault) rawCause = CAUSE_LOCK;
    else                rawCause = CAUSE_NONE;
    scLost     = dec.storeCond && !resvHeld;
    swallow    = (dec.strXfer && lenZero) || dec.touch;
    suppress   = (rawCause != CAUSE_NONE) && (scLost || swallow);
    finalCause = suppress ? CAUSE_NONE : rawCause;
  end

  always_ff @(posedge clk) begin
    if (rst || !inValid) begin
      resValid <= 1'b0;
      cause    <= CAUSE_NONE;
      irqReq   <= 1'b0;
      noOp     <= 1'b0;
      scFail   <= 1'b0;
    end else begin
      resValid <= 1'b1;
      cause    <= finalCause;
      irqReq   <= finalCause != CAUSE_NONE;
      noOp     <= swallow && (rawCause != CAUSE_NONE);
      scFail   <= scLost;
    end
  end

  a_r1_user_write: assert property (@(posedge clk) disable iff (rst)
    (inValid && dec.doesWrite && !dec.storeCond && !dec.strXfer &&
     userMode && !pageUserWr) |=> (cause == CAUSE_WRITE && irqReq));

  a_r3_icache_lock: assert property (@(posedge clk) disable iff (rst)
    (inValid && userMode && dec.icInval && icUserLock) |=>
    (cause == CAUSE_LOCK && irqReq));

  a_r6_sc_quiet: assert property (@(posedge clk) disable iff (rst)
    scFail |-> !irqReq || cause == CAUSE_WRITE);

  a_r8_noop_quiet: assert property (@(posedge clk) disable iff (rst)
    noOp |-> (!irqReq && cause == CAUSE_NONE));

  a_r10_idle: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> (!resValid && !irqReq && !noOp && !scFail));

endmodule

// File: rtl/dsx_checker.sv
module dsx_checker
  import dsx_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [CLS_W-1:0]   accClass,
  input  logic               userMode,
  input  logic               pageUserWr,
  input  logic               pageSupWr,
  input  logic               pageLittle,
  input  logic [1:0]         copOrderOk,
  input  logic               icUserLock,
  input  logic               dcUserLock,
  input  logic               resvHeld,
  input  logic               lenZero,
  output logic               resValid,
  output logic [CAUSE_W-1:0] cause,
  output logic               irqReq,
  output logic               noOp,
  output logic               scFail
);

  clsDecode_t dec;

  dsx_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .accClass (accClass),
    .dec      (dec)
  );

  dsx_datapath u_dp (
    .clk        (clk),
    .rst        (rst),
    .inValid    (inValid),
    .dec        (dec),
    .userMode   (userMode),
    .pageUserWr (pageUserWr),
    .pageSupWr  (pageSupWr),
    .pageLittle (pageLittle),
    .copOrderOk (copOrderOk),
    .icUserLock (icUserLock),
    .dcUserLock (dcUserLock),
    .resvHeld   (resvHeld),
    .lenZero    (lenZero),
    .resValid   (resValid),
    .cause      (cause),
    .irqReq     (irqReq),
    .noOp       (noOp),
    .scFail     (scFail)
  );

  // R11: first cycle after reset is quiet
  a_r11_reset_clear: assert property (@(posedge clk)
    rst |=> (!resValid && cause == 3'd0 && !irqReq && !noOp && !scFail));

endmodule

// File: tb/sim_dsx_checker.sv
module sim_dsx_checker;

  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [3:0] accClass = '0;
  logic userMode = 1'b0, pageUserWr = 1'b0, pageSupWr = 1'b0, pageLittle = 1'b0;
  logic [1:0] copOrderOk = '0;
  logic icUserLock = 1'b0, dcUserLock = 1'b0, resvHeld = 1'b0, lenZero = 1'b0;
  logic resValid, irqReq, noOp, scFail;
  logic [2:0] cause;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  dsx_checker u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .accClass(accClass),
    .userMode(userMode), .pageUserWr(pageUserWr), .pageSupWr(pageSupWr),
    .pageLittle(pageLittle), .copOrderOk(copOrderOk),
    .icUserLock(icUserLock), .dcUserLock(dcUserLock),
    .resvHeld(resvHeld), .lenZero(lenZero),
    .resValid(resValid), .cause(cause), .irqReq(irqReq),
    .noOp(noOp), .scFail(scFail)
  );

  // Behavioural model: returns {resValid, cause[2:0], irqReq, noOp, scFail}
  function automatic logic [6:0] model(
    input logic v, input int cls, input logic um, input logic uw, input logic sw,
    input logic le, input logic [1:0] cs, input logic il, input logic dl,
    input logic rs, input logic zl);
    int c;
    logic writes, sc, quiet, nop, fail;
    if (!v) return 7'd0;
    writes = (cls == 2 || cls == 3 || cls == 4 || cls == 5 || cls == 9 || cls == 11);
    c = 0;
    if (writes && ((um && !uw) || (!um && !sw))) c = 1;
    else if ((cls == 8 || cls == 9) && cs[le] == 1'b0) c = 2;
    else if (um && ((cls == 6 && il) || (cls == 7 && dl))) c = 3;
    sc = (cls == 3);
    fail = sc && !rs;
    quiet = 0; nop = 0;
    if (c != 0 && fail) quiet = 1;
    if (c != 0 && (((cls == 10 || cls == 11) && zl) || cls == 12 || cls == 13)) begin
      quiet = 1; nop = 1;
    end
    if (quiet) c = 0;
    return {1'b1, 3'(c), (c != 0), nop, fail};
  endfunction

  task automatic compare(input string tag, input logic [6:0] exp);
    logic [6:0] got;
    got = {resValid, cause, irqReq, noOp, scFail};
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got={v%b c%0d i%b n%b s%b} exp={v%b c%0d i%b n%b s%b}", tag,
               got[6], got[5:3], got[2], got[1], got[0],
               exp[6], exp[5:3], exp[2], exp[1], exp[0]);
    end
  endtask

  // Drive at a negedge, check at the next negedge (one register stage)
  task automatic run(input string tag, input logic v, input int cls, input logic um,
                     input logic uw, input logic sw, input logic le, input logic [1:0] cs,
                     input logic il, input logic dl, input logic rs, input logic zl);
    logic [6:0] exp;
    inValid = v; accClass = 4'(cls); userMode = um; pageUserWr = uw; pageSupWr = sw;
    pageLittle = le; copOrderOk = cs; icUserLock = il; dcUserLock = dl;
    resvHeld = rs; lenZero = zl;
    exp = model(v, cls, um, uw, sw, le, cs, il, dl, rs, zl);
    @(negedge clk);
    compare(tag, exp);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R11", 7'd0);
    rst = 1'b0;
    @(negedge clk);
    // R1: user-mode write to user-read-only page
    run("R1", 1, 2, 1, 0, 1, 0, 2'b11, 0, 0, 1, 0);
    run("R1", 1, 4, 1, 0, 1, 0, 2'b11, 0, 0, 1, 0);
    run("R1", 1, 5, 1, 1, 0, 0, 2'b11, 0, 0, 1, 0);
    // R2: supervisor uses supervisor bit, ignores user bit
    run("R2", 1, 2, 0, 1, 0, 0, 2'b11, 0, 0, 1, 0);
    run("R2", 1, 2, 0, 0, 1, 0, 2'b11, 0, 0, 1, 0);
    // R3: icache invalidate lock
    run("R3", 1, 6, 1, 1, 1, 0, 2'b11, 1, 0, 1, 0);
    run("R3", 1, 6, 0, 1, 1, 0, 2'b11, 1, 0, 1, 0);
    run("R3", 1, 6, 1, 1, 1, 0, 2'b11, 0, 1, 1, 0);
    // R4: dcache flush lock
    run("R4", 1, 7, 1, 1, 1, 0, 2'b11, 0, 1, 1, 0);
    run("R4", 1, 7, 0, 1, 1, 0, 2'b11, 0, 1, 1, 0);
    run("R4", 1, 7, 1, 1, 1, 0, 2'b11, 1, 0, 1, 0);
    // R5: byte ordering
    run("R5", 1, 8, 1, 1, 1, 1, 2'b01, 0, 0, 1, 0);
    run("R5", 1, 8, 1, 1, 1, 0, 2'b01, 0, 0, 1, 0);
    run("R5", 1, 1, 1, 1, 1, 1, 2'b00, 0, 0, 1, 0);
    run("R5", 1, 2, 1, 1, 1, 0, 2'b00, 0, 0, 1, 0);
    // R6: store-conditional lost reservation swallows write fault
    run("R6", 1, 3, 1, 0, 1, 0, 2'b11, 0, 0, 0, 0);
    run("R6", 1, 3, 0, 1, 0, 0, 2'b11, 0, 0, 0, 0);
    // R7: store-conditional with reservation
    run("R7", 1, 3, 1, 1, 1, 0, 2'b11, 0, 0, 1, 0);
    run("R7", 1, 3, 1, 0, 1, 0, 2'b11, 0, 0, 1, 0);
    run("R7", 1, 3, 1, 1, 1, 0, 2'b11, 0, 0, 0, 0);
    // R8: zero-length string and touches
    run("R8", 1, 11, 1, 0, 1, 0, 2'b11, 0, 0, 1, 1);
    run("R8", 1, 11, 1, 0, 1, 0, 2'b11, 0, 0, 1, 0);
    run("R8", 1, 12, 1, 0, 0, 1, 2'b00, 1, 1, 0, 1);
    run("R8", 1, 13, 1, 0, 0, 1, 2'b00, 1, 1, 0, 0);
    // R9: coprocessor store with both faults -> write wins
    run("R9", 1, 9, 1, 0, 1, 1, 2'b01, 1, 1, 1, 0);
    run("R9", 1, 9, 1, 1, 1, 1, 2'b01, 1, 1, 1, 0);
    // R10: idle cycle clears outputs
    run("R10", 1, 2, 1, 0, 0, 0, 2'b11, 0, 0, 1, 0);
    run("R10", 0, 2, 1, 0, 0, 0, 2'b11, 0, 0, 1, 0);
    // Randomized back-to-back stream
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] r;
      r = 16'($urandom);
      run("R9", (r[15:13] != 3'd0), int'(r[3:0]), r[4], r[5], r[6], r[7], r[9:8],
          r[10], r[11], r[12], r[13]);
    end
    // R11: reset mid-stream
    inValid = 1'b1; accClass = 4'd2; userMode = 1'b1; pageUserWr = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    compare("R11", 7'd0);
    rst = 1'b0;
    inValid = 1'b0;
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule